// File: doc/BRIEF.md
# Capture/Compare/PWM Unit

This block drives a single pin in one of three ways, using timer values that arrive from outside. A 16-bit free-running count feeds capture and compare. A 10-bit period count, which comes with a pulse that marks the start of each period, feeds PWM. Software uses a small register port with three byte-wide registers: a low data byte, a high data byte and a control byte. Bits 3:0 of the control byte select the function. Bits 5:4 carry the two fine bits of the PWM duty.

In capture modes, a qualifying edge on the input pin copies the 16-bit count into the two data bytes. The qualifying edge can be every falling edge, every rising edge, or every fourth or sixteenth rising edge. In compare modes, the two data bytes form a 16-bit reference. The first cycle in which the count equals the reference sets the pin, clears the pin, only flags, or also emits a one-cycle trigger pulse. In PWM modes, the pin goes high at each period start and low once the period count reaches a double-buffered 10-bit duty.

Every capture or compare event produces a single-cycle interrupt pulse, which an outside flag register collects.

Top module: `ccp_unit`

## Requirements
- R1: After reset the control byte reads 0, and `pin_out`, `irq_pulse` and `trig_pulse` are 0. The register selects are 0 for the low data byte, 1 for the high data byte and 2 for the control byte. The mode is control bits 3:0 and the fine duty bits are control bits 5:4.
- R2: In mode 0100, a falling pin edge loads the 16-bit count into the data bytes, with the low byte taking bits 7:0. A rising edge loads nothing.
- R3: In mode 0101, a rising pin edge loads the count. A falling edge loads nothing.
- R4: In mode 0110, only every fourth rising edge loads the count.
- R5: In mode 0111, only every sixteenth rising edge loads the count. The edge counter restarts from zero whenever a control write changes the mode.
- R6: Writing mode 1000 drives the pin low. The first cycle in which the count equals {high, low} drives it high, and it stays high.
- R7: Writing mode 1001 drives the pin high. A match drives it low, and it stays low.
- R8: In mode 1010, a match produces only the interrupt pulse. The pin stays low and no trigger pulse appears.
- R9: In mode 1011, a match produces a one-cycle trigger pulse together with the interrupt pulse.
- R10: Any mode 11xx is PWM with duty D = {low byte, control bits 5:4}. On the cycle after the period-start pulse the pin is high when D is nonzero. It goes low after the cycle in which the period count equals D.
- R11: A change to the duty takes effect only at the next period-start pulse.
- R12: A duty of zero keeps the pin low for the whole period.
- R13: In mode 0000 there are no events, the pin stays low and pin edges do not alter the data bytes.
- R14: Each capture or compare event produces exactly one `irq_pulse`, in the cycle after the edge or match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 low, 1 high, 2 control |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read source, same encoding as `wr_sel` |
| rd_data | output | 8 | Read data (combinational) |
| tmr_val | input | 16 | Free-running 16-bit count |
| pwm_cnt | input | 10 | Extended period count |
| pwm_wrap | input | 1 | Period-start pulse, coincides with count 0 |
| pin_in | input | 1 | Capture pin input |
| pin_out | output | 1 | Compare/PWM pin output |
| irq_pulse | output | 1 | One-cycle event pulse for the interrupt flag |
| trig_pulse | output | 1 | One-cycle special-event trigger |

## Verification
The bench exercises the prescaled capture modes.

- **Edge counting.** It counts edges exactly. A counter that is off by one, or that is not cleared on a mode change, fires an edge early: after the switch from divide-by-4 to divide-by-16 that is the fourteenth edge instead of the sixteenth.
- **Compare entry state and repeated matches.** It checks the pin level on entry to each compare mode and holds the count on the reference for only a single cycle. A design that re-fires on every matching cycle, or that starts the pin at the wrong level, shows extra pulses or a wrong pin.
- **PWM buffering and duty edges.** It rewrites the duty in the middle of a period. A design without a shadow register cuts the current pulse short. It also runs zero duty and a duty made only of the fine bits, which catches a design that drops the fine bits or glitches high at the period start.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
   localparam logic [3:0] M_OFF      = 4'b0000;
   localparam logic [3:0] M_CAP_FALL = 4'b0100;
   localparam logic [3:0] M_CAP_RISE = 4'b0101;
   localparam logic [3:0] M_CAP_R4   = 4'b0110;
   localparam logic [3:0] M_CAP_R16  = 4'b0111;
   localparam logic [3:0] M_CMP_SET  = 4'b1000;
   localparam logic [3:0] M_CMP_CLR  = 4'b1001;
   localparam logic [3:0] M_CMP_SOFT = 4'b1010;
   localparam logic [3:0] M_CMP_EVT  = 4'b1011;

   localparam logic [1:0] SEL_LO  = 2'd0;
   localparam logic [1:0] SEL_HI  = 2'd1;
   localparam logic [1:0] SEL_CTL = 2'd2;

   function automatic logic is_pwm(input logic [3:0] m);
      return m[3:2] == 2'b11;
   endfunction

   function automatic logic is_cmp(input logic [3:0] m);
      return m[3:2] == 2'b10;
   endfunction
endpackage

// File: rtl/ccp_capture.sv
module ccp_capture
   import ccp_pkg::*;
#(
   parameter int DIV_LO = 4,
   parameter int DIV_HI = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] mode,
   input  logic       mode_chg,
   input  logic       pin_rise,
   input  logic       pin_fall,
   output logic       fire
);
   localparam int CNT_W = $clog2(DIV_HI);
   localparam logic [CNT_W-1:0] LIM_LO = CNT_W'(DIV_LO - 1);
   localparam logic [CNT_W-1:0] LIM_HI = CNT_W'(DIV_HI - 1);

   if (DIV_LO < 2 || DIV_HI <= DIV_LO) begin : g_bad_div
      $error("ccp_capture: need 2 <= DIV_LO < DIV_HI");
   end

   logic [CNT_W-1:0] edge_cnt;
   logic             scaled;
   logic [CNT_W-1:0] lim;

   assign scaled = (mode == M_CAP_R4) || (mode == M_CAP_R16);
   assign lim    = (mode == M_CAP_R4) ? LIM_LO : LIM_HI;

   always_ff @(posedge clk) begin
      if (!rst_n)                 edge_cnt <= '0;
      else if (mode_chg)          edge_cnt <= '0;
      else if (scaled && pin_rise) edge_cnt <= (edge_cnt == lim) ? '0 : edge_cnt + 1'b1;
   end

   always_comb begin
      unique case (mode)
         M_CAP_FALL: fire = pin_fall;
         M_CAP_RISE: fire = pin_rise;
         M_CAP_R4,
         M_CAP_R16:  fire = pin_rise && (edge_cnt == lim);
         default:    fire = 1'b0;
      endcase
   end

   AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg |=> (edge_cnt == '0)); // R5
   AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_CAP_R4 && !mode_chg) |=> (edge_cnt <= LIM_LO) || $past(edge_cnt > LIM_LO)); // R4
endmodule

// File: rtl/ccp_compare.sv
module ccp_compare
   import ccp_pkg::*;
#(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [3:0]    mode,
   input  logic          load,
   input  logic [3:0]    load_mode,
   input  logic [TW-1:0] tmr,
   input  logic [TW-1:0] ref_val,
   output logic          fire,
   output logic          out_q,
   output logic          trig_q
);
   logic hit, hit_q;

   assign hit  = is_cmp(mode) && (tmr == ref_val);
   assign fire = hit && !hit_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_q  <= 1'b0;
         out_q  <= 1'b0;
         trig_q <= 1'b0;
      end else begin
         hit_q  <= hit;
         trig_q <= fire && (mode == M_CMP_EVT);
         if (load)
            out_q <= (load_mode == M_CMP_CLR);
         else if (fire && mode == M_CMP_SET)
            out_q <= 1'b1;
         else if (fire && mode == M_CMP_CLR)
            out_q <= 1'b0;
      end
   end

   AST_SET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_CMP_SET && out_q && !load) |=> out_q); // R6
   AST_CLR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_CMP_CLR && !out_q && !load) |=> !out_q); // R7
   AST_TRIG_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      trig_q |-> ($past(mode) == M_CMP_EVT)); // R9
endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm #(
   parameter int PW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          wrap,
   input  logic [PW-1:0] cnt,
   input  logic [PW-1:0] duty_new,
   output logic          out_q
);
   logic [PW-1:0] duty_act;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         duty_act <= '0;
         out_q    <= 1'b0;
      end else if (!en) begin
         out_q <= 1'b0;
      end else if (wrap) begin
         duty_act <= duty_new;
         out_q    <= (duty_new != '0);
      end else if (cnt == duty_act) begin
         out_q <= 1'b0;
      end
   end

   AST_PWM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_act == '0) |-> !out_q); // R12
   AST_PWM_BUF: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(duty_act)); // R11
endmodule

// File: rtl/ccp_unit.sv
module ccp_unit
   import ccp_pkg::*;
#(
   parameter int DB          = 8,
   parameter int TW          = 16,
   parameter int PW          = 10,
   parameter int SYNC_STAGES = 0,
   parameter int DIV_LO      = 4,
   parameter int DIV_HI      = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_sel,
   input  logic [DB-1:0] wr_data,
   input  logic [1:0]    rd_sel,
   output logic [DB-1:0] rd_data,
   input  logic [TW-1:0] tmr_val,
   input  logic [PW-1:0] pwm_cnt,
   input  logic          pwm_wrap,
   input  logic          pin_in,
   output logic          pin_out,
   output logic          irq_pulse,
   output logic          trig_pulse
);
   localparam int FINE_W = PW - DB;
   localparam int CTLW   = 4 + FINE_W;

   if (TW != 2 * DB) begin : g_bad_tw
      $error("ccp_unit: TW must be twice DB");
   end
   if (FINE_W < 1 || CTLW > DB) begin : g_bad_pw
      $error("ccp_unit: PW must exceed DB and leave room in the control byte");
   end

   logic [DB-1:0]   lo_q, hi_q;
   logic [CTLW-1:0] ctl_q;
   logic [3:0]      mode;
   logic            wr_lo, wr_hi, wr_ctl, mode_chg;
   logic            pin_s, pin_q, pin_rise, pin_fall;
   logic            cap_fire, cmp_fire, cmp_out, cmp_trig, pwm_out;
   logic            irq_q;

   assign mode     = ctl_q[3:0];
   assign wr_lo    = wr_en && (wr_sel == SEL_LO);
   assign wr_hi    = wr_en && (wr_sel == SEL_HI);
   assign wr_ctl   = wr_en && (wr_sel == SEL_CTL);
   assign mode_chg = wr_ctl && (wr_data[3:0] != mode);

   if (SYNC_STAGES == 0) begin : g_nosync
      assign pin_s = pin_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk) begin
         if (!rst_n) sh <= '0;
         else        sh <= (sh << 1) | SYNC_STAGES'(pin_in);
      end
      assign pin_s = sh[SYNC_STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pin_q <= 1'b0;
      else        pin_q <= pin_s;
   end
   assign pin_rise = pin_s && !pin_q;
   assign pin_fall = !pin_s && pin_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q  <= '0;
         hi_q  <= '0;
         ctl_q <= '0;
         irq_q <= 1'b0;
      end else begin
         irq_q <= cap_fire || cmp_fire;
         if (wr_ctl) ctl_q <= wr_data[CTLW-1:0];
         if (cap_fire) begin
            {hi_q, lo_q} <= tmr_val;
         end else begin
            if (wr_lo) lo_q <= wr_data;
            if (wr_hi) hi_q <= wr_data;
         end
      end
   end

   ccp_capture #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_cap (
      .clk(clk), .rst_n(rst_n), .mode(mode), .mode_chg(mode_chg),
      .pin_rise(pin_rise), .pin_fall(pin_fall), .fire(cap_fire)
   );

   ccp_compare #(.TW(TW)) u_cmp (
      .clk(clk), .rst_n(rst_n), .mode(mode), .load(wr_ctl),
      .load_mode(wr_data[3:0]), .tmr(tmr_val), .ref_val({hi_q, lo_q}),
      .fire(cmp_fire), .out_q(cmp_out), .trig_q(cmp_trig)
   );

   ccp_pwm #(.PW(PW)) u_pwm (
      .clk(clk), .rst_n(rst_n), .en(is_pwm(mode)), .wrap(pwm_wrap),
      .cnt(pwm_cnt), .duty_new({lo_q, ctl_q[CTLW-1:4]}), .out_q(pwm_out)
   );

   always_comb begin
      if (is_pwm(mode))      pin_out = pwm_out;
      else if (is_cmp(mode)) pin_out = cmp_out;
      else                   pin_out = 1'b0;
   end

   always_comb begin
      unique case (rd_sel)
         SEL_LO:  rd_data = lo_q;
         SEL_HI:  rd_data = hi_q;
         SEL_CTL: rd_data = DB'(ctl_q);
         default: rd_data = '0;
      endcase
   end

   assign irq_pulse  = irq_q;
   assign trig_pulse = cmp_trig;

   AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cap_fire |=> ({hi_q, lo_q} == $past(tmr_val))); // R2
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> ($past(mode) != M_OFF)); // R13
   AST_TRIG_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |-> irq_pulse); // R14
endmodule

// File: tb/ccp_unit_bench.sv
`timescale 1ns/1ps
module ccp_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [7:0]  wr_data = 8'd0;
   logic [1:0]  rd_sel = 2'd0;
   logic [7:0]  rd_data;
   logic [15:0] tmr_val = 16'd0;
   logic [9:0]  pwm_cnt = 10'd0;
   logic        pwm_wrap = 1'b0;
   logic        pin_in = 1'b0;
   logic        pin_out, irq_pulse, trig_pulse;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   logic [1:0] exp_q[$];   // {trig, pin} expected with each irq pulse

   always #10 clk = ~clk;

   ccp_unit u_ccp_unit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .tmr_val(tmr_val), .pwm_cnt(pwm_cnt),
      .pwm_wrap(pwm_wrap), .pin_in(pin_in), .pin_out(pin_out),
      .irq_pulse(irq_pulse), .trig_pulse(trig_pulse)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever the event pulse appears
   always @(negedge clk) begin
      if (rst_n && !done && irq_pulse) begin
         checks++;
         if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL R14 unexpected event actual=1 expected=0");
         end else begin
            logic [1:0] e;
            e = exp_q.pop_front();
            if ({trig_pulse, pin_out} !== e) begin
               failures++;
               $display("FAIL R14 event content actual=%b expected=%b", {trig_pulse, pin_out}, e);
            end
         end
      end else if (rst_n && !done && trig_pulse) begin
         checks++; failures++;
         $display("FAIL R9 trigger without event actual=1 expected=0");
      end
   end

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [7:0] d);
      rd_sel = sel;
      #1 d = rd_data;
   endtask

   task automatic pin_to(input logic v, input bit expect_ev);
      if (expect_ev) exp_q.push_back(2'b00);
      pin_in = v;
      step();
   endtask

   task automatic drained(input string tag);
      check(tag, exp_q.size(), 0);
   endtask

   task automatic pwm_period(input int len, input int duty, input string tag,
                             input bit mid_wr, input logic [7:0] mid_lo);
      for (int c = 0; c < len; c++) begin
         pwm_cnt = 10'(c); pwm_wrap = (c == 0);
         if (mid_wr && c == 4) begin wr_en = 1'b1; wr_sel = 2'd0; wr_data = mid_lo; end
         step();
         wr_en = 1'b0; pwm_wrap = 1'b0;
         check(tag, pin_out, (c < duty) ? 1 : 0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [7:0] a, b;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      rd(2'd2, a); check("R1 ctrl", a, 8'h00);
      check("R1 pin", pin_out, 0); check("R1 irq", irq_pulse, 0); check("R1 trig", trig_pulse, 0);

      // R2 falling-edge capture
      wr(2'd2, 8'h04); tmr_val = 16'h1234;
      pin_to(1, 0); pin_to(0, 1);
      rd(2'd0, a); rd(2'd1, b); check("R2 low", a, 8'h34); check("R2 high", b, 8'h12);
      tmr_val = 16'h5555; pin_to(1, 0); step();
      rd(2'd0, a); check("R2 rising ignored", a, 8'h34);
      drained("R2 events");

      // R3 rising-edge capture
      wr(2'd2, 8'h05); tmr_val = 16'hBEEF;
      pin_to(0, 0); pin_to(1, 1);
      rd(2'd0, a); rd(2'd1, b); check("R3 low", a, 8'hEF); check("R3 high", b, 8'hBE);
      tmr_val = 16'h0001; pin_to(0, 0); step();
      rd(2'd0, a); check("R3 falling ignored", a, 8'hEF);
      drained("R3 events");

      // R4 every fourth rising edge
      wr(2'd2, 8'h06);
      for (int i = 1; i <= 4; i++) begin
         tmr_val = 16'h0A00 + 16'(i);
         pin_to(1, i == 4); pin_to(0, 0);
         if (i == 3) begin rd(2'd0, a); check("R4 not yet", a, 8'hEF); end
      end
      rd(2'd0, a); rd(2'd1, b); check("R4 low", a, 8'h04); check("R4 high", b, 8'h0A);
      drained("R4 events");

      // R5 every sixteenth rising edge, counter restarts on mode change
      pin_to(1, 0); pin_to(0, 0); pin_to(1, 0); pin_to(0, 0);
      wr(2'd2, 8'h07);
      for (int i = 1; i <= 16; i++) begin
         tmr_val = 16'h7700 + 16'(i);
         pin_to(1, i == 16); pin_to(0, 0);
         if (i == 14) begin rd(2'd0, a); check("R5 no early capture", a, 8'h04); end
      end
      rd(2'd0, a); rd(2'd1, b); check("R5 low", a, 8'h10); check("R5 high", b, 8'h77);
      drained("R5 events");

      // R6 set on match
      tmr_val = 16'h0000;
      wr(2'd0, 8'h50); wr(2'd1, 8'h00); wr(2'd2, 8'h08);
      check("R6 entry low", pin_out, 0);
      exp_q.push_back(2'b01); tmr_val = 16'h0050; step();
      check("R6 high", pin_out, 1);
      tmr_val = 16'h0051; step(); step(); check("R6 stays", pin_out, 1);
      drained("R6 events");

      // R7 clear on match
      tmr_val = 16'h0000; wr(2'd2, 8'h09);
      check("R7 entry high", pin_out, 1);
      exp_q.push_back(2'b00); tmr_val = 16'h0050; step();
      check("R7 low", pin_out, 0);
      tmr_val = 16'h0000; step(); check("R7 stays", pin_out, 0);
      drained("R7 events");

      // R8 flag only
      wr(2'd2, 8'h0A);
      exp_q.push_back(2'b00); tmr_val = 16'h0050; step();
      tmr_val = 16'h0000; step(); check("R8 pin", pin_out, 0);
      drained("R8 events");

      // R9 special-event trigger
      wr(2'd2, 8'h0B);
      exp_q.push_back(2'b10); tmr_val = 16'h0050; step();
      tmr_val = 16'h0000; step(); check("R9 trigger one cycle", trig_pulse, 0);
      drained("R9 events");

      // R13 off: no events, no capture
      wr(2'd2, 8'h00);
      tmr_val = 16'h0050; step(); step();
      tmr_val = 16'hFFFF;
      pin_to(1, 0); pin_to(0, 0); pin_to(1, 0); pin_to(0, 0);
      rd(2'd0, a); rd(2'd1, b); check("R13 low kept", a, 8'h50); check("R13 high kept", b, 8'h00);
      check("R13 pin", pin_out, 0);
      drained("R13 events");

      // R10 PWM duty {0x02,01}=9, R11 mid-period rewrite, R12 zero duty
      wr(2'd0, 8'h02); wr(2'd2, 8'h1C);
      pwm_period(16, 9, "R10 duty 9", 1, 8'h01);
      pwm_period(16, 5, "R11 buffered duty 5", 0, 8'h00);
      wr(2'd0, 8'h00); wr(2'd2, 8'h3F);
      pwm_period(16, 3, "R10 mode 1111 duty 3", 0, 8'h00);
      wr(2'd2, 8'h0C);
      pwm_period(16, 0, "R12 zero duty", 0, 8'h00);
      drained("R14 all events seen");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule